// File: doc/BRIEF.md
# Misaligned Access Splitting Unit

This unit sits between the load/store port of a processor and a 32-bit memory bus. It takes one data request at a time (byte, halfword or word, read or write) at any byte address. When the address does not fit the natural alignment of the size, the unit turns the request into a short series of naturally aligned bus pieces. It never faults on an unaligned address.

For a store, each piece carries its own aligned address, size code and byte-enable mask, and the data is rotated so that every byte sits on the lane that matches its address. For a load, the unit collects the bytes returned by the pieces into one right-justified, zero-extended result. It then raises a one-cycle done pulse.

The processor side uses a valid/ready handshake. The bus side uses a request/acknowledge handshake, and a piece held by wait states stalls the whole series.

Top module: `mas_split`

## Requirements
- R1: The size codes are 2'b00 byte, 2'b01 halfword and 2'b10 word. Code 2'b11 is treated as word. A byte request, a halfword request at an even address and a word request at an address with bits [1:0] = 2'b00 are each done as exactly one bus piece of the same size at the request address.
- R2: A halfword request at an odd address is done as two byte pieces, first at A and then at A+1.
- R3: A word request with address bits [1:0] = 2'b10 is done as two halfword pieces, first at A and then at A+2.
- R4: A word request at an odd address is done as three pieces in ascending address order: a byte at A, a halfword at A+1, then a byte at A+3. Addresses wrap modulo 2^ADDR_W.
- R5: Every piece drives `bus_addr` with its own byte address, which is aligned to its size. It drives `bus_size` with the size code from R1. `bus_be` is 4'b0001, 4'b0011 or 4'b1111 for byte, halfword or word, shifted left by `bus_addr[1:0]`.
- R6: For a store, request data byte i (bits [8i+7:8i] of `req_wdata`) appears on bus lane (A+i) mod 4 in every piece that enables that lane.
- R7: For a load, the byte at address A+i is placed in bits [8i+7:8i] of `resp_rdata`. Bits above the request size read as zero, and lanes not enabled by a piece do not affect the result.
- R8: `req_ready` is high exactly when the unit is idle. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_valid` while busy is ignored and does not disturb the pieces in flight.
- R9: A piece stays on the bus with stable address, size, enables and data until `bus_ack` is sampled high. The next piece appears in the cycle after that acknowledge.
- R10: `resp_done` is a one-cycle pulse in the cycle after the last piece is acknowledged, with the result on `resp_rdata`. For a store, `resp_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Request size code |
| req_addr | input | ADDR_W | Request byte address |
| req_wdata | input | 32 | Right-justified store data |
| resp_done | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 32 | Merged, zero-extended load data |
| bus_req | output | 1 | Piece on the bus |
| bus_ack | input | 1 | Piece acknowledged this cycle |
| bus_write | output | 1 | Piece is a store |
| bus_addr | output | ADDR_W | Aligned piece byte address |
| bus_size | output | 2 | Piece size code |
| bus_be | output | 4 | Piece byte enables |
| bus_wdata | output | 32 | Lane-steered store data |
| bus_rdata | input | 32 | Piece read data, lane-aligned |

## Verification
The bench builds the unit with ADDR_W = 16. This keeps the address space small enough that an odd word request near the top of the space wraps its last byte piece to address zero, so the modulo rule in R4 is exercised directly. A 16-byte bus model with per-piece wait states stands behind the unit. This brings into reach the stall rule of R9, the ignored requests of R8 while a piece waits, and the merge of R7 with unrelated data on disabled lanes.

// File: rtl/mas_pkg.sv
package mas_pkg;

    localparam int LANES      = 4;
    localparam int LANE_W     = 8;
    localparam int BUS_W      = LANES * LANE_W;
    localparam int IDX_W      = 2;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } size_e;

    // one aligned piece of a request: byte offset from request address and size
    typedef struct packed {
        logic [1:0] off;
        size_e      size;
    } piece_t;

endpackage

// File: rtl/mas_plan.sv
module mas_plan
    import mas_pkg::*;
(
    input  logic [1:0]       size_i,
    input  logic [1:0]       lsb_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [IDX_W-1:0] count_o,
    output piece_t           piece_o
);

    always_comb begin
        count_o      = 2'd1;
        piece_o.off  = 2'd0;
        piece_o.size = SZ_BYTE;
        case (size_i)
            SZ_BYTE: begin
                count_o      = 2'd1;
                piece_o.size = SZ_BYTE;
            end
            SZ_HALF: begin
                if (lsb_i[0]) begin
                    // two bytes, ascending
                    count_o      = 2'd2;
                    piece_o.size = SZ_BYTE;
                    piece_o.off  = (idx_i == 2'd0) ? 2'd0 : 2'd1;
                end else begin
                    count_o      = 2'd1;
                    piece_o.size = SZ_HALF;
                end
            end
            default: begin
                // word and reserved code
                if (lsb_i == 2'b00) begin
                    count_o      = 2'd1;
                    piece_o.size = SZ_WORD;
                end else if (lsb_i == 2'b10) begin
                    count_o      = 2'd2;
                    piece_o.size = SZ_HALF;
                    piece_o.off  = (idx_i == 2'd0) ? 2'd0 : 2'd2;
                end else begin
                    count_o = 2'd3;
                    case (idx_i)
                        2'd0: begin
                            piece_o.off  = 2'd0;
                            piece_o.size = SZ_BYTE;
                        end
                        2'd1: begin
                            piece_o.off  = 2'd1;
                            piece_o.size = SZ_HALF;
                        end
                        default: begin
                            piece_o.off  = 2'd3;
                            piece_o.size = SZ_BYTE;
                        end
                    endcase
                end
            end
        endcase
    end

endmodule

// File: rtl/mas_lanes.sv
module mas_lanes
    import mas_pkg::*;
(
    input  logic [1:0]       req_lsb_i,
    input  logic [BUS_W-1:0] wdata_i,
    input  logic [1:0]       piece_lane_i,
    input  size_e            piece_size_i,
    input  logic [BUS_W-1:0] rdata_i,
    input  logic [BUS_W-1:0] acc_i,
    output logic [BUS_W-1:0] wdata_o,
    output logic [LANES-1:0] be_o,
    output logic [BUS_W-1:0] merged_o
);

    logic [LANES-1:0] base_be;

    always_comb begin
        case (piece_size_i)
            SZ_BYTE: base_be = 4'b0001;
            SZ_HALF: base_be = 4'b0011;
            default: base_be = 4'b1111;
        endcase
        be_o = base_be << piece_lane_i;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [1:0] src_byte;
        logic [1:0] src_lane;

        // store: lane g carries request byte (g - A) mod 4
        assign src_byte = 2'(g) - req_lsb_i;
        assign wdata_o[g*LANE_W +: LANE_W] = wdata_i[{src_byte, 3'b000} +: LANE_W];

        // load: result byte g comes from lane (A + g) mod 4
        assign src_lane = req_lsb_i + 2'(g);
        assign merged_o[g*LANE_W +: LANE_W] = be_o[src_lane]
                                            ? rdata_i[{src_lane, 3'b000} +: LANE_W]
                                            : acc_i[g*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/mas_split.sv
module mas_split
    import mas_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              resp_done,
    output logic [31:0]       resp_rdata,
    output logic              bus_req,
    input  logic              bus_ack,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic [3:0]        bus_be,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata
);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic              write;
        logic [1:0]        size;
        logic [ADDR_W-1:0] addr;
        logic [BUS_W-1:0]  wdata;
        logic [IDX_W-1:0]  idx;
        logic [BUS_W-1:0]  acc;
    } state_t;

    state_t st_d, st_q;

    logic [IDX_W-1:0]  count;
    logic [IDX_W-1:0]  last_idx;
    piece_t            piece;
    logic [ADDR_W-1:0] piece_addr;
    logic [BUS_W-1:0]  steer_wdata;
    logic [LANES-1:0]  piece_be;
    logic [BUS_W-1:0]  merged;

    mas_plan u_plan (
        .size_i  (st_q.size),
        .lsb_i   (st_q.addr[1:0]),
        .idx_i   (st_q.idx),
        .count_o (count),
        .piece_o (piece)
    );

    assign piece_addr = st_q.addr + ADDR_W'(piece.off);
    assign last_idx   = count - 2'd1;

    mas_lanes u_lanes (
        .req_lsb_i    (st_q.addr[1:0]),
        .wdata_i      (st_q.wdata),
        .piece_lane_i (piece_addr[1:0]),
        .piece_size_i (piece.size),
        .rdata_i      (bus_rdata),
        .acc_i        (st_q.acc),
        .wdata_o      (steer_wdata),
        .be_o         (piece_be),
        .merged_o     (merged)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (req_valid) begin
                st_d.busy  = 1'b1;
                st_d.write = req_write;
                st_d.size  = req_size;
                st_d.addr  = req_addr;
                st_d.wdata = req_wdata;
                st_d.idx   = '0;
                st_d.acc   = '0;
            end
        end else if (bus_ack) begin
            if (!st_q.write) begin
                st_d.acc = merged;
            end
            if (st_q.idx == last_idx) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.idx = st_q.idx + 2'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready  = !st_q.busy;
    assign resp_done  = st_q.done;
    assign resp_rdata = st_q.acc;
    assign bus_req    = st_q.busy;
    assign bus_write  = st_q.write;
    assign bus_addr   = piece_addr;
    assign bus_size   = piece.size;
    assign bus_be     = piece_be;
    assign bus_wdata  = steer_wdata;

endmodule

// File: rtl/mas_split_chk.sv
module mas_split_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              resp_done,
    input logic [31:0]       resp_rdata,
    input logic              bus_req,
    input logic              bus_ack,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_size,
    input logic [3:0]        bus_be,
    input logic [31:0]       bus_wdata
);

    assert_piece_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_size)
                                && $stable(bus_be) && $stable(bus_wdata) && $stable(bus_write));

    assert_be_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> $countones(bus_be) == ((bus_size == 2'b00) ? 1 : (bus_size == 2'b01) ? 2 : 4));

    assert_piece_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> bus_be[bus_addr[1:0]] && !(bus_size == 2'b01 && bus_addr[0])
                    && !(bus_size == 2'b10 && bus_addr[1:0] != 2'b00));

    assert_idle_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && bus_req));

    assert_start_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(req_valid && req_ready));

    assert_done_after_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        resp_done |-> $past(bus_req && bus_ack));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        resp_done |=> !resp_done);

    assert_store_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        resp_done && $past(bus_write) |-> resp_rdata == 32'h0);

endmodule

bind mas_split mas_split_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .resp_done  (resp_done),
    .resp_rdata (resp_rdata),
    .bus_req    (bus_req),
    .bus_ack    (bus_ack),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_size   (bus_size),
    .bus_be     (bus_be),
    .bus_wdata  (bus_wdata)
);

// File: tb/mas_split_bench.sv
`timescale 1ns/1ps
module mas_split_bench;

    localparam int AW = 16;

    typedef struct packed {
        logic        we;
        logic [1:0]  size;
        logic [15:0] addr;
        logic [31:0] wdata;
        logic [1:0]  n;
        logic [3:0]  waits;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b0, 2'd0, 16'h0005, 32'h0,         2'd1, 4'd0},
        '{1'b0, 2'd1, 16'h0004, 32'h0,         2'd1, 4'd1},
        '{1'b0, 2'd1, 16'h0007, 32'h0,         2'd2, 4'd0},
        '{1'b0, 2'd2, 16'h0008, 32'h0,         2'd1, 4'd0},
        '{1'b0, 2'd2, 16'h000A, 32'h0,         2'd2, 4'd2},
        '{1'b0, 2'd2, 16'h0009, 32'h0,         2'd3, 4'd0},
        '{1'b0, 2'd2, 16'h000B, 32'h0,         2'd3, 4'd1},
        '{1'b0, 2'd3, 16'h000C, 32'h0,         2'd1, 4'd0},
        '{1'b0, 2'd2, 16'hFFFD, 32'h0,         2'd3, 4'd0},
        '{1'b1, 2'd0, 16'h0003, 32'hAABBCCDD,  2'd1, 4'd1},
        '{1'b1, 2'd1, 16'h0001, 32'h11223344,  2'd2, 4'd0},
        '{1'b1, 2'd2, 16'h0006, 32'h55667788,  2'd2, 4'd2},
        '{1'b1, 2'd2, 16'h000F, 32'h99AABBCC,  2'd3, 4'd1},
        '{1'b1, 2'd2, 16'h0004, 32'hDEADBEEF,  2'd1, 4'd0},
        '{1'b0, 2'd2, 16'h0006, 32'h0,         2'd2, 4'd0},
        '{1'b0, 2'd2, 16'h000D, 32'h0,         2'd3, 4'd3}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic          req_ready;
    logic          req_write;
    logic [1:0]    req_size;
    logic [AW-1:0] req_addr;
    logic [31:0]   req_wdata;
    logic          resp_done;
    logic [31:0]   resp_rdata;
    logic          bus_req;
    logic          bus_ack;
    logic          bus_write;
    logic [AW-1:0] bus_addr;
    logic [1:0]    bus_size;
    logic [3:0]    bus_be;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata;

    logic [7:0] mem [16];
    int n_cmp = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    always #4 clk = ~clk;

    mas_split #(.ADDR_W(AW)) u_mas_split (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_size   (req_size),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .resp_done  (resp_done),
        .resp_rdata (resp_rdata),
        .bus_req    (bus_req),
        .bus_ack    (bus_ack),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_size   (bus_size),
        .bus_be     (bus_be),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // expected piece k of a request, from R1..R4: {offset, size}
    function automatic logic [3:0] exp_piece(input logic [1:0] sz, input logic [1:0] lsb, input int k);
        if (sz == 2'd0) return {2'd0, 2'd0};
        if (sz == 2'd1) begin
            if (!lsb[0]) return {2'd0, 2'd1};
            return (k == 0) ? {2'd0, 2'd0} : {2'd1, 2'd0};
        end
        if (lsb == 2'b00) return {2'd0, 2'd2};
        if (lsb == 2'b10) return (k == 0) ? {2'd0, 2'd1} : {2'd2, 2'd1};
        if (k == 0) return {2'd0, 2'd0};
        if (k == 1) return {2'd1, 2'd1};
        return {2'd3, 2'd0};
    endfunction

    function automatic string shape_tag(input logic [1:0] sz, input logic [1:0] lsb);
        if (sz == 2'd0) return "R1";
        if (sz == 2'd1) return lsb[0] ? "R2" : "R1";
        if (lsb == 2'b00) return "R1";
        if (lsb == 2'b10) return "R3";
        return "R4";
    endfunction

    task automatic run(input vec_t v, input bit poke);
        int nb;
        int k;
        int w;
        int guard;
        bit fin;
        bit want_done;
        logic [3:0]  ep;
        logic [15:0] pa;
        logic [3:0]  ebe;
        logic [31:0] expr;
        logic [7:0]  shadow [16];
        logic [15:0] h_addr;
        logic [3:0]  h_be;
        logic [31:0] h_wd;
        string tag;

        tag    = shadow_dummy(v);
        nb     = (v.size == 2'd0) ? 1 : (v.size == 2'd1) ? 2 : 4;
        expr   = '0;
        shadow = mem;
        for (int i = 0; i < nb; i++) begin
            expr[8*i +: 8] = mem[(v.addr + 16'(i)) & 16'hF];
            if (v.we) shadow[(v.addr + 16'(i)) & 16'hF] = v.wdata[8*i +: 8];
        end

        @(negedge clk);
        chk(req_ready == 1'b1, "R8 idle ready", 32'(req_ready), 32'h1);
        req_valid = 1'b1;
        req_write = v.we;
        req_size  = v.size;
        req_addr  = v.addr;
        req_wdata = v.wdata;
        @(posedge clk);
        @(negedge clk);
        if (poke) begin
            req_write = ~v.we;
            req_size  = 2'd0;
            req_addr  = v.addr + 16'h0005;
            req_wdata = 32'hFFFF_FFFF;
        end else begin
            req_valid = 1'b0;
        end

        k = 0; w = 0; guard = 0; fin = 1'b0; want_done = 1'b0;
        h_addr = '0; h_be = '0; h_wd = '0;
        while (!fin && guard < 200) begin
            guard++;
            if (want_done) begin
                chk(resp_done == 1'b1, "R10 done after last ack", 32'(resp_done), 32'h1);
                want_done = 1'b0;
            end
            if (resp_done) begin
                fin     = 1'b1;
                bus_ack = 1'b0;
            end else if (bus_req) begin
                if (poke && k == 0)
                    chk(req_ready == 1'b0, "R8 busy not ready", 32'(req_ready), 32'h0);
                if (w == 0) begin
                    ep  = exp_piece(v.size, v.addr[1:0], k);
                    pa  = v.addr + 16'(ep[3:2]);
                    ebe = ((ep[1:0] == 2'd0) ? 4'b0001 : (ep[1:0] == 2'd1) ? 4'b0011 : 4'b1111) << pa[1:0];
                    chk(bus_addr == pa, {tag, " piece address"}, 32'(bus_addr), 32'(pa));
                    chk(bus_size == ep[1:0], "R5 piece size", 32'(bus_size), 32'(ep[1:0]));
                    chk(bus_be == ebe, "R5 piece enables", 32'(bus_be), 32'(ebe));
                    if (v.we) begin
                        for (int j = 0; j < 4; j++) begin
                            if (ebe[(pa[1:0] + 2'(j))]) begin
                                chk(bus_wdata[8*(pa[1:0] + 2'(j)) +: 8] == v.wdata[8*(ep[3:2] + 2'(j)) +: 8],
                                    "R6 lane data", 32'(bus_wdata[8*(pa[1:0] + 2'(j)) +: 8]),
                                    32'(v.wdata[8*(ep[3:2] + 2'(j)) +: 8]));
                            end
                        end
                    end
                end else begin
                    chk(bus_addr == h_addr && bus_be == h_be && bus_wdata == h_wd,
                        "R9 piece held during wait", 32'(bus_addr), 32'(h_addr));
                end
                h_addr = bus_addr; h_be = bus_be; h_wd = bus_wdata;
                if (w < int'(v.waits)) begin
                    bus_ack   = 1'b0;
                    bus_rdata = 32'h0;
                    w++;
                end else begin
                    bus_ack = 1'b1;
                    for (int l = 0; l < 4; l++)
                        bus_rdata[8*l +: 8] = mem[{bus_addr[3:2], 2'(l)}];
                    if (bus_write) begin
                        for (int l = 0; l < 4; l++)
                            if (bus_be[l]) mem[{bus_addr[3:2], 2'(l)}] = bus_wdata[8*l +: 8];
                    end
                    k++;
                    w = 0;
                    if (poke) req_valid = 1'b0;
                    if (k == int'(v.n)) want_done = 1'b1;
                end
            end else begin
                bus_ack = 1'b0;
            end
            if (!fin) begin
                @(posedge clk);
                @(negedge clk);
            end
        end
        bus_ack   = 1'b0;
        req_valid = 1'b0;

        chk(k == int'(v.n), {tag, " piece count"}, 32'(k), 32'(v.n));
        if (v.we) begin
            chk(resp_rdata == 32'h0, "R10 store result zero", resp_rdata, 32'h0);
            for (int i = 0; i < 16; i++)
                chk(mem[i] == shadow[i], "R6 memory after store", 32'(mem[i]), 32'(shadow[i]));
        end else begin
            chk(resp_rdata == expr, "R7 merged load", resp_rdata, expr);
        end
        @(negedge clk);
        chk(resp_done == 1'b0, "R10 done one cycle", 32'(resp_done), 32'h0);
    endtask

    function automatic string shadow_dummy(input vec_t v);
        return shape_tag(v.size, v.addr[1:0]);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R9 watchdog act=hung exp=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 8'(i * 17 + 3);
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_write = 1'b0;
        req_size  = 2'd0;
        req_addr  = '0;
        req_wdata = '0;
        bus_ack   = 1'b0;
        bus_rdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready == 1'b1, "R8 reset ready", 32'(req_ready), 32'h1);
        chk(bus_req == 1'b0, "R9 reset no piece", 32'(bus_req), 32'h0);
        chk(resp_done == 1'b0, "R10 reset no done", 32'(resp_done), 32'h0);
        rst_n = 1'b1;

        // idle with no request: no piece appears (R8)
        repeat (3) @(negedge clk);
        chk(bus_req == 1'b0, "R8 no request no piece", 32'(bus_req), 32'h0);

        for (int t = 0; t < NV; t++) run(VECS[t], 1'b0);

        // requests offered while busy are ignored (R8)
        run('{1'b0, 2'd2, 16'h0003, 32'h0, 2'd3, 4'd3}, 1'b1);
        run('{1'b1, 2'd1, 16'h0009, 32'h0BADF00D, 2'd2, 4'd2}, 1'b1);

        // odd word load across the top of the address space after stores (R4, R7)
        run('{1'b0, 2'd2, 16'hFFFF, 32'h0, 2'd3, 4'd0}, 1'b0);

        // unaligned byte-enable isolation: halfword at lane 2 (R1, R7)
        run('{1'b0, 2'd1, 16'h000E, 32'h0, 2'd1, 4'd0}, 1'b0);

        finish_run();
    end

endmodule